// File: doc/BRIEF.md
# Clock-Ratio Switch Sequencer

This block changes the core clock ratio by talking to a configuration register port. On a start pulse it takes a mode index and looks up a 32-bit power-mode word in a table fixed at build time. It then issues three writes to the power control register. The first write clears the high half. The second clears the low half. The third loads the low half with the chosen word. After the writes it reads a 64-bit power status register repeatedly until the change is confirmed or a retry limit is reached.

Between two status reads the block leaves the port idle for a fixed time. That time is set in microseconds and converted to clock cycles from the clock frequency. When the sequence ends, the requested index becomes the current mode, even if confirmation never came. In that case a timeout flag is raised.

A separate query operation reads the status register once. It reports the first table entry whose speed request matches the speed the hardware reports. Only full-speed and half-speed entries are in the default table.

Top module: `fswitch_seq`

## Requirements
- R1: After reset, busy_o, done_o, timeout_o and reg_req_o are 0, and cur_mode_o and query_idx_o are 0.
- R2: A start accepted in idle (start_i high, mode_i below NUM_MODES) issues three writes to address 0x0AA001, in this order: data 0x00000000, then data 0x80000000 (bit 31 set means the low half), then 0x80000000 OR the table word for mode_i. Table word 0 is 0x00010000 and word 1 is 0x00030000, with the speed request in bits 19:17.
- R3: The register port holds reg_req_o high, with reg_we_o, reg_addr_o and reg_wdata_o stable, until reg_ack_i. A transfer ends on the cycle where both are high, and the next transfer starts only after that.
- R4: After the third write the block reads address 0x408001. A poll passes when bit 61 is 0 and status bits 57:56 equal word bits 18:17. A poll also passes whenever bit 60 is 1. On a pass the sequence ends.
- R5: After a failed poll that is not the last one, reg_req_o stays low for exactly POLL_WAIT_US × CLK_HZ/1e6 cycles before the next read.
- R6: At most MAX_POLLS (10) status reads are made. When the tenth read fails, the sequence ends with timeout_o = 1.
- R7: When a sequence ends, cur_mode_o takes the requested index whatever the poll result. done_o pulses for one cycle, in the first cycle where busy_o is low.
- R8: timeout_o is cleared when a start is accepted and otherwise keeps its value, including across queries.
- R9: While busy_o is high, start_i and query_i are ignored.
- R10: A start with mode_i at or above NUM_MODES is ignored. No transfer is made and busy_o stays low.
- R11: A query in idle makes one read of 0x408001. It sets query_idx_o to the lowest index whose word bits 18:17 equal status bits 57:56, or to NUM_MODES if there is none. It pulses done_o and leaves cur_mode_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a ratio switch |
| mode_i | input | IDX_W | Requested mode index |
| query_i | input | 1 | Start a speed query |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| cur_mode_o | output | IDX_W | Current mode index |
| query_idx_o | output | IDX_W | Result of the last query |
| timeout_o | output | 1 | Last switch ran out of polls |
| reg_req_o | output | 1 | Register port request |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wdata_o | output | 32 | Write data |
| reg_ack_i | input | 1 | Register port acknowledge |
| reg_rdata_i | input | 64 | Read data, valid with acknowledge |

## Verification
A wrong sequencer state shows up on the register port at once, as a write out of order, a missing clear, or an extra or missing status read. The scoreboard catches it at the acknowledge of the transfer that first differs. A wrong poll decision or retry count changes the number of reads and the timeout flag, and this is visible at the done pulse. A wrong wait count changes the idle gap before the next read and is flagged when that read begins. A wrong query scan shows in query_idx_o at the done pulse of that query.

// File: rtl/fsw_pkg.sv
// Shared constants and state type for the clock-ratio switch sequencer.
// Assumes a 24-bit configuration address space and the fixed bit layout
// of the power control and power status registers.
package fsw_pkg;
    localparam logic [23:0] CTRL_ADDR   = 24'h0AA001;
    localparam logic [23:0] STAT_ADDR   = 24'h408001;
    localparam int          LO_SEL_BIT  = 31;
    localparam int          SPD_LSB     = 17;
    localparam int          RCVD_BIT    = 61;
    localparam int          CMPL_BIT    = 60;
    localparam int          CUR_SPD_LSB = 56;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR_HI,
        ST_CLR_LO,
        ST_SET_LO,
        ST_POLL,
        ST_WAIT,
        ST_QUERY
    } fsw_state_e;
endpackage

// File: rtl/fsw_status_eval.sv
// Decides whether one status read confirms the requested speed.
// Assumes the caller passes the received/completed flags, the reported
// speed bits and the low two speed-request bits of the target word.
module fsw_status_eval (
    input  logic       rcvd_i,
    input  logic       cmpl_i,
    input  logic [1:0] cur_spd_i,
    input  logic [1:0] req_spd_i,
    output logic       pass_o
);
    // Pass on accepted-and-matching, or on completed.
    always_comb pass_o = (!rcvd_i && (cur_spd_i == req_spd_i)) || cmpl_i;
endmodule

// File: rtl/fsw_mode_match.sv
// Finds the lowest table index whose speed request equals the reported
// speed; returns NUM_MODES when no entry matches. Purely combinational.
module fsw_mode_match #(
    parameter int NUM_MODES = 2,
    parameter int IDX_W     = 2,
    parameter logic [NUM_MODES*32-1:0] MODE_TABLE = '0
) (
    input  logic [1:0]       cur_spd_i,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the top down so the lowest matching index wins.
    always_comb begin
        idx_o = IDX_W'(NUM_MODES);
        for (int i = NUM_MODES - 1; i >= 0; i--) begin
            if (MODE_TABLE[i*32 + fsw_pkg::SPD_LSB +: 2] == cur_spd_i)
                idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/fsw_poll_timer.sv
// Down-counter for the idle gap between status polls. Loading starts a
// window of WAIT_CYC cycles; expired_o is high in its last cycle and when idle.
module fsw_poll_timer #(
    parameter int WAIT_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(WAIT_CYC + 1);
    logic [CNT_W-1:0] cnt;

    // Reload on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (load_i)        cnt <= CNT_W'(WAIT_CYC - 1);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    always_comb expired_o = (cnt == '0);
endmodule

// File: rtl/fswitch_seq.sv
// Clock-ratio switch sequencer. It writes clear-high, clear-low and
// set-low to the power control register, then polls the power status
// register with a bounded retry count and a fixed wait between polls.
// It also offers a one-read speed query. Assumes a request/acknowledge
// port where the slave answers every request with a one-cycle ack.
module fswitch_seq #(
    parameter int NUM_MODES    = 2,
    parameter logic [NUM_MODES*32-1:0] MODE_TABLE = {32'h0003_0000, 32'h0001_0000},
    parameter int MAX_POLLS    = 10,
    parameter int CLK_HZ       = 125_000_000,
    parameter int POLL_WAIT_US = 100,
    parameter int ADDR_W       = 24,
    parameter int IDX_W        = $clog2(NUM_MODES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  mode_i,
    input  logic              query_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [IDX_W-1:0]  cur_mode_o,
    output logic [IDX_W-1:0]  query_idx_o,
    output logic              timeout_o,
    output logic              reg_req_o,
    output logic              reg_we_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [31:0]       reg_wdata_o,
    input  logic              reg_ack_i,
    input  logic [63:0]       reg_rdata_i
);
    import fsw_pkg::*;

    localparam int WAIT_RAW = (CLK_HZ / 1_000_000) * POLL_WAIT_US;
    localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
    localparam int PCNT_W   = $clog2(MAX_POLLS + 1);

    fsw_state_e        state;
    logic [IDX_W-1:0]  tgt;
    logic [PCNT_W-1:0] pcnt;
    logic [31:0]       tgt_word;
    logic              poll_pass;
    logic              poll_last;
    logic              poll_retry;
    logic              wait_done;
    logic              mode_ok;
    logic [IDX_W-1:0]  scan_idx;
    logic              rdata_unused;

    assign rdata_unused = ^{reg_rdata_i[63:62], reg_rdata_i[59:58], reg_rdata_i[55:0]};

    // Look up the table word of the latched target mode.
    always_comb begin
        tgt_word = '0;
        for (int i = 0; i < NUM_MODES; i++)
            if (tgt == IDX_W'(i)) tgt_word = MODE_TABLE[i*32 +: 32];
    end

    fsw_status_eval u_eval (
        .rcvd_i    (reg_rdata_i[RCVD_BIT]),
        .cmpl_i    (reg_rdata_i[CMPL_BIT]),
        .cur_spd_i (reg_rdata_i[CUR_SPD_LSB +: 2]),
        .req_spd_i (tgt_word[SPD_LSB +: 2]),
        .pass_o    (poll_pass)
    );

    fsw_mode_match #(
        .NUM_MODES  (NUM_MODES),
        .IDX_W      (IDX_W),
        .MODE_TABLE (MODE_TABLE)
    ) u_match (
        .cur_spd_i (reg_rdata_i[CUR_SPD_LSB +: 2]),
        .idx_o     (scan_idx)
    );

    // Decode poll outcome and start-acceptance conditions.
    always_comb begin
        mode_ok    = (mode_i < IDX_W'(NUM_MODES));
        poll_last  = (pcnt == PCNT_W'(MAX_POLLS - 1));
        poll_retry = (state == ST_POLL) && reg_ack_i && !poll_pass && !poll_last;
    end

    fsw_poll_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (poll_retry),
        .expired_o (wait_done)
    );

    // Main sequencer: write sequence, bounded poll loop and query.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            tgt         <= '0;
            pcnt        <= '0;
            cur_mode_o  <= '0;
            query_idx_o <= '0;
            timeout_o   <= 1'b0;
            done_o      <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i && mode_ok) begin
                        tgt       <= mode_i;
                        pcnt      <= '0;
                        timeout_o <= 1'b0;
                        state     <= ST_CLR_HI;
                    end else if (query_i) begin
                        state <= ST_QUERY;
                    end
                end
                ST_CLR_HI: if (reg_ack_i) state <= ST_CLR_LO;
                ST_CLR_LO: if (reg_ack_i) state <= ST_SET_LO;
                ST_SET_LO: if (reg_ack_i) state <= ST_POLL;
                ST_POLL: begin
                    if (reg_ack_i) begin
                        if (poll_pass || poll_last) begin
                            timeout_o  <= !poll_pass;
                            cur_mode_o <= tgt;
                            done_o     <= 1'b1;
                            state      <= ST_IDLE;
                        end else begin
                            pcnt  <= pcnt + 1'b1;
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: if (wait_done) state <= ST_POLL;
                ST_QUERY: begin
                    if (reg_ack_i) begin
                        query_idx_o <= scan_idx;
                        done_o      <= 1'b1;
                        state       <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the register port from the current state.
    always_comb begin
        busy_o      = (state != ST_IDLE);
        reg_req_o   = (state != ST_IDLE) && (state != ST_WAIT);
        reg_we_o    = (state == ST_CLR_HI) || (state == ST_CLR_LO) || (state == ST_SET_LO);
        reg_addr_o  = reg_we_o ? ADDR_W'(CTRL_ADDR) : ADDR_W'(STAT_ADDR);
        reg_wdata_o = '0;
        if (state == ST_CLR_LO) reg_wdata_o[LO_SEL_BIT] = 1'b1;
        if (state == ST_SET_LO) reg_wdata_o = tgt_word | (32'd1 << LO_SEL_BIT);
    end
endmodule

// File: rtl/fswitch_seq_chk.sv
// Protocol checker for fswitch_seq, attached by bind. Checks port holding,
// address use, done/busy timing, timeout clearing and the poll bound.
module fswitch_seq_chk #(
    parameter int MAX_POLLS = 10,
    parameter int ADDR_W    = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              timeout_o,
    input logic              reg_req_o,
    input logic              reg_we_o,
    input logic [ADDR_W-1:0] reg_addr_o,
    input logic [31:0]       reg_wdata_o,
    input logic              reg_ack_i
);
    localparam int RC_W = $clog2(MAX_POLLS + 2);
    logic [RC_W-1:0] rd_cnt;

    // Count status reads completed within one busy period.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_o)                         rd_cnt <= '0;
        else if (reg_req_o && reg_ack_i && !reg_we_o)  rd_cnt <= rd_cnt + 1'b1;
    end

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && !reg_ack_i) |=> (reg_req_o && $stable(reg_we_o)
            && $stable(reg_addr_o) && $stable(reg_wdata_o)));

    assert_write_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && reg_we_o) |-> (reg_addr_o == ADDR_W'(24'h0AA001)));

    assert_read_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && !reg_we_o) |-> (reg_addr_o == ADDR_W'(24'h408001)));

    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_timeout_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !$past(busy_o) && reg_we_o) |-> !timeout_o);

    assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= RC_W'(MAX_POLLS));
endmodule

bind fswitch_seq fswitch_seq_chk #(.MAX_POLLS(MAX_POLLS), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/fswitch_seq_tb_top.sv
`timescale 1ns/1ps
module fswitch_seq_tb_top;
    localparam int W_CYC = 125;              // 1 us at 125 MHz
    localparam logic [63:0] DEF_STAT = 64'h2300_0000_0000_0000; // received, speed 3

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic        query_i = 1'b0;
    logic        busy_o, done_o, timeout_o, reg_req_o, reg_we_o;
    logic [1:0]  cur_mode_o, query_idx_o;
    logic [23:0] reg_addr_o;
    logic [31:0] reg_wdata_o;
    logic        reg_ack_i = 1'b0;
    logic [63:0] reg_rdata_i = '0;

    always #4 clk = ~clk;

    fswitch_seq #(.POLL_WAIT_US(1)) dut_i (.*);

    typedef struct { logic we; logic [23:0] addr; logic [31:0] data; } xfer_t;
    typedef struct { logic is_q; logic [1:0] idx; logic to; } res_t;
    xfer_t       exp_x[$];
    res_t        exp_r[$];
    logic [63:0] stat_q[$];
    logic [31:0] words [2] = '{32'h0001_0000, 32'h0003_0000};

    int checks = 0, errors = 0;
    logic [1:0] model_cur = '0;
    int lat = 0, wait_n = 0, lowcnt = 0;
    bit measuring = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Register slave and transfer monitor: acks with varying latency.
    always @(negedge clk) begin
        if (rst_n) begin
            if (measuring && busy_o) begin
                if (!reg_req_o) lowcnt++;
                else begin
                    check(lowcnt == W_CYC, "R5 poll gap", 64'(lowcnt), 64'(W_CYC));
                    measuring = 0;
                end
            end
            if (reg_ack_i) reg_ack_i = 1'b0;
            else if (reg_req_o) begin
                if (wait_n == lat) begin
                    xfer_t e;
                    wait_n = 0;
                    lat = (lat + 1) % 3;
                    reg_ack_i = 1'b1;
                    if (exp_x.size() == 0) begin
                        check(0, "R9 unexpected transfer", {8'(reg_we_o), reg_addr_o, reg_wdata_o}, 0);
                    end else begin
                        e = exp_x.pop_front();
                        check(reg_we_o == e.we && reg_addr_o == e.addr && (!e.we || reg_wdata_o == e.data),
                              e.we ? "R2 control write" : "R4 status read",
                              {8'(reg_we_o), reg_addr_o, reg_wdata_o}, {8'(e.we), e.addr, e.data});
                    end
                    if (!reg_we_o) begin
                        reg_rdata_i = (stat_q.size() != 0) ? stat_q.pop_front() : DEF_STAT;
                        measuring = 1; lowcnt = 0;
                    end
                end else wait_n++;
            end
        end
    end

    // Result monitor: compares each done pulse with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            measuring = 0;
            if (exp_r.size() == 0) check(0, "R9 unexpected done", 1, 0);
            else begin
                res_t r;
                r = exp_r.pop_front();
                check(!busy_o, "R7 busy low at done", 64'(busy_o), 0);
                check(timeout_o == r.to, "R6 timeout flag", 64'(timeout_o), 64'(r.to));
                if (r.is_q) begin
                    check(query_idx_o == r.idx, "R11 query index", 64'(query_idx_o), 64'(r.idx));
                    check(cur_mode_o == model_cur, "R11 cur mode kept", 64'(cur_mode_o), 64'(model_cur));
                end else
                    check(cur_mode_o == r.idx, "R7 cur mode", 64'(cur_mode_o), 64'(r.idx));
            end
        end
    end

    task automatic wait_idle(input bit inject, input logic [1:0] other);
        int n = 0;
        while (busy_o) begin
            @(negedge clk);
            n++;
            if (inject && n == 5) begin start_i = 1'b1; query_i = 1'b1; mode_i = other; end
            else begin start_i = 1'b0; query_i = 1'b0; end
        end
        start_i = 1'b0; query_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Driver: pushes the expected transfers and result of one switch.
    task automatic run_switch(input logic [1:0] m, input bit inject);
        bit ok = 0;
        int nrd = 0;
        logic [63:0] s;
        exp_x.push_back('{1'b1, 24'h0AA001, 32'h0000_0000});
        exp_x.push_back('{1'b1, 24'h0AA001, 32'h8000_0000});
        exp_x.push_back('{1'b1, 24'h0AA001, 32'h8000_0000 | words[m]});
        for (int k = 0; k < 10 && !ok; k++) begin
            s = (k < stat_q.size()) ? stat_q[k] : DEF_STAT;
            nrd++;
            ok = (!s[61] && s[57:56] == words[m][18:17]) || s[60];
        end
        for (int k = 0; k < nrd; k++) exp_x.push_back('{1'b0, 24'h408001, 32'h0});
        exp_r.push_back('{1'b0, m, !ok});
        model_cur = m;
        @(negedge clk); start_i = 1'b1; mode_i = m;
        @(negedge clk); start_i = 1'b0;
        check(busy_o, "R2 busy after start", 64'(busy_o), 1);
        check(!timeout_o, "R8 timeout cleared on start", 64'(timeout_o), 0);
        wait_idle(inject, m ^ 2'd1);
    endtask

    task automatic run_query(input logic [63:0] s);
        logic [1:0] idx = 2'd2;
        for (int i = 1; i >= 0; i--) if (words[i][18:17] == s[57:56]) idx = 2'(i);
        stat_q.push_back(s);
        exp_x.push_back('{1'b0, 24'h408001, 32'h0});
        exp_r.push_back('{1'b1, idx, timeout_o});
        @(negedge clk); query_i = 1'b1;
        @(negedge clk); query_i = 1'b0;
        wait_idle(0, 2'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !timeout_o && !reg_req_o, "R1 reset flags",
              {busy_o, done_o, timeout_o, reg_req_o}, 0);
        check(cur_mode_o == 0 && query_idx_o == 0, "R1 reset indices", {cur_mode_o, query_idx_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: immediate pass on accepted-and-matching (half speed).
        stat_q.push_back(64'h0100_0000_0000_0000);
        run_switch(2'd1, 0);
        // R4: received twice, then completed flag passes (full speed).
        stat_q.push_back(64'h2000_0000_0000_0000);
        stat_q.push_back(64'h2100_0000_0000_0000);
        stat_q.push_back(64'h3100_0000_0000_0000);
        run_switch(2'd0, 0);
        // R4: speed mismatch without received flag fails, then matches.
        stat_q.push_back(64'h0000_0000_0000_0000);
        stat_q.push_back(64'h0100_0000_0000_0000);
        run_switch(2'd1, 0);
        // R6: no confirmation at all; ten reads and timeout.
        run_switch(2'd0, 0);
        check(timeout_o, "R6 timeout held", 64'(timeout_o), 1);
        // R8/R11: query keeps timeout; three speed patterns.
        run_query(64'h0100_0000_0000_0000);
        check(timeout_o, "R8 timeout kept over query", 64'(timeout_o), 1);
        run_query(64'h0000_0000_0000_0000);
        run_query(64'h0300_0000_0000_0000);
        // R9: start and query pulsed while busy are ignored.
        stat_q.push_back(64'h2000_0000_0000_0000);
        stat_q.push_back(64'h0100_0000_0000_0000);
        run_switch(2'd1, 1);
        // R10: out-of-range mode is ignored.
        for (int m = 2; m < 4; m++) begin
            @(negedge clk); start_i = 1'b1; mode_i = 2'(m);
            @(negedge clk); start_i = 1'b0;
            check(!busy_o && !reg_req_o, "R10 invalid mode ignored", {busy_o, reg_req_o}, 0);
            repeat (4) @(negedge clk);
            check(cur_mode_o == 2'd1, "R10 cur mode unchanged", 64'(cur_mode_o), 1);
        end
        check(exp_x.size() == 0 && exp_r.size() == 0, "R3 scoreboard drained",
              64'(exp_x.size() + exp_r.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule